// File: doc/BRIEF.md
# Supervision Input Filter with Change Interrupt

This block cleans up the hook and ground-key style supervision signals coming from four line-interface channels and tells a host when any of them changes. Each channel carries two raw inputs. The first input goes through a two-flop synchronizer and then a hold-time filter. That filter accepts a new level only after the level has stayed put for a programmed number of 1 ms ticks. The second input goes through the same synchronizer and then a saturating up/down integrator. The integrator samples once every programmed number of ticks and switches its output with hysteresis.

The eight filtered bits form a live status word. The host reads it either whole or one channel at a time, and any read pulse acknowledges the interrupt. The active-low interrupt falls when an unmasked status bit changes and stays low until a read. A change that lands in the same cycle as the read keeps it low. Settings arrive through a simple write port that selects a kind, a channel and a data value: hold time, sample interval or mask pair.

The design is built from explicit state machines. The hold-time filter has two states. `DB_STABLE` moves to `DB_TIMING` when the input differs from the output and the hold time is nonzero. `DB_TIMING` returns to `DB_STABLE` in two cases: on a bounce back to the old level, or when the count completes. The integrator has two states. `IG_LOW` moves to `IG_HIGH` when a sample brings the count to its ceiling. `IG_HIGH` moves back to `IG_LOW` when a sample brings the count to zero. The interrupt has two states. `IRQ_IDLE` moves to `IRQ_PEND` on an unmasked change. `IRQ_PEND` moves back to `IRQ_IDLE` on a read in a cycle with no unmasked change.

Top module: `sup_filter_irq`

## Requirements
- R1: With a hold time of 0, a new level on a first input appears in its status bit on the third rising clock edge after the input changes, and not on the second.
- R2: With a hold time T from 1 to 15, the status bit takes the new level on the rising edge that samples the T-th tick counted after the synchronized input differs. It does not change on earlier ticks.
- R3: If the synchronized first input returns to the current status level before the count completes, the count is discarded. A later change must again wait a full T ticks.
- R4: The second input's integrator counts up on a high sample and down on a low sample. It saturates at 0 and at 7. The status bit goes high when the count reaches 7. Extra high samples beyond 7 do not lengthen the later fall: exactly 7 low samples then bring it low.
- R5: Once high, the second-input status bit stays high until the count reaches 0. A partial dip (3 low samples followed by 3 high samples) does not clear it.
- R6: With a sample interval setting N (0..15), the integrator samples on every (N+1)-th tick. Writing the interval of a channel restarts that channel's tick phase, so the first sample falls on the (N+1)-th tick after the write.
- R7: When `rd_all` is 1, `rd_data` carries the whole status word: bit 2c is channel c's first-input status and bit 2c+1 is its second-input status. When `rd_all` is 0, `rd_data[1:0]` carries channel `rd_ch` as {second, first} and the upper bits read 0.
- R8: When an unmasked status bit changes on a clock edge, `int_n` goes low on the following edge. It then stays low while no read pulse occurs.
- R9: Mask bits are written with kind 2. `cfg_data[0]` masks channel `cfg_ch`'s first-input bit and `cfg_data[1]` masks its second-input bit. A masked bit's change leaves `int_n` high.
- R10: A read pulse (`rd_en` high for one cycle) raises `int_n` on that edge. The exception is an unmasked status change pending in the same cycle: then `int_n` stays low.
- R11: After reset, all status bits are 0, `int_n` is 1, and all hold times, intervals and masks are 0. Write kinds are 0 for hold time and 1 for interval, with the value in `cfg_data[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| raw_a | input | 4 | First supervision input per channel (asynchronous) |
| raw_b | input | 4 | Second supervision input per channel (asynchronous) |
| cfg_we | input | 1 | Setting write strobe |
| cfg_kind | input | 2 | 0 hold time, 1 sample interval, 2 mask pair, 3 ignored |
| cfg_ch | input | 2 | Channel addressed by a write |
| cfg_data | input | 4 | Setting value |
| rd_en | input | 1 | Status read pulse; acknowledges the interrupt |
| rd_all | input | 1 | 1 selects the whole status word, 0 one channel |
| rd_ch | input | 2 | Channel for a single-channel read |
| rd_data | output | 8 | Status read data |
| int_n | output | 1 | Active-low change interrupt |

## Verification
The hardest case to reach from the ports is a status change that becomes visible in exactly the cycle of an acknowledging read. The bench first leaves the interrupt pending from an earlier change. It then toggles a raw input on a channel with zero hold time and counts the three register stages to that channel's status bit. It raises the read pulse for the single cycle in which the change is pending, and expects `int_n` to stay low. Integrator hysteresis is also reached only through long, precisely counted tick trains per interval setting. The bench therefore sweeps every channel across several intervals and every hold time, and predicts each flip edge arithmetically.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic {
        DB_STABLE,
        DB_TIMING
    } deb_st_e;

    typedef enum logic {
        IG_LOW,
        IG_HIGH
    } intg_st_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_PEND
    } irq_st_e;

    typedef enum logic [1:0] {
        CFG_HOLD     = 2'd0,
        CFG_INTERVAL = 2'd1,
        CFG_MASK     = 2'd2,
        CFG_SPARE    = 2'd3
    } cfg_kind_e;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce
    import sup_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          din,
    input  logic [TW-1:0] hold,
    output logic          dout
);
    localparam logic [TW:0] ONE = (TW+1)'(1);

    deb_st_e       state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic          out_q, out_d;
    logic [TW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + ONE;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_STABLE;
            cnt_q   <= '0;
            out_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            out_q   <= out_d;
        end
    end

    // next state and next output
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        out_d   = out_q;
        unique case (state_q)
            DB_STABLE: begin
                if (din != out_q) begin
                    if (hold == '0) begin
                        out_d = din;
                    end else begin
                        state_d = DB_TIMING;
                        cnt_d   = '0;
                    end
                end
            end
            DB_TIMING: begin
                if (din == out_q) begin
                    state_d = DB_STABLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_inc >= {1'b0, hold}) begin
                        out_d   = din;
                        state_d = DB_STABLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[TW-1:0];
                    end
                end
            end
        endcase
    end

    assign dout = out_q;
endmodule

// File: rtl/sup_integrator.sv
module sup_integrator
    import sup_pkg::*;
#(
    parameter int CW = 3,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  logic          din,
    input  logic [IW-1:0] interval,
    output logic          dout
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};
    localparam logic [CW-1:0] CONE = CW'(1);
    localparam logic [IW-1:0] IONE = IW'(1);

    intg_st_e      state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [IW-1:0] tmr_q, tmr_d;
    logic          sample;

    assign sample = tick && !restart && (tmr_q >= interval);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IG_LOW;
            cnt_q   <= '0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tmr_q   <= tmr_d;
        end
    end

    // sample timer
    always_comb begin
        tmr_d = tmr_q;
        if (restart)
            tmr_d = '0;
        else if (sample)
            tmr_d = '0;
        else if (tick)
            tmr_d = tmr_q + IONE;
    end

    // counter and state transitions
    always_comb begin
        cnt_d   = cnt_q;
        state_d = state_q;
        if (sample) begin
            if (din) begin
                if (cnt_q != CMAX) cnt_d = cnt_q + CONE;
            end else begin
                if (cnt_q != '0) cnt_d = cnt_q - CONE;
            end
            unique case (state_q)
                IG_LOW:  if (cnt_d == CMAX) state_d = IG_HIGH;
                IG_HIGH: if (cnt_d == '0)   state_d = IG_LOW;
            endcase
        end
    end

    // output
    always_comb dout = (state_q == IG_HIGH);
endmodule

// File: rtl/sup_irq.sv
module sup_irq
    import sup_pkg::*;
#(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] stat,
    input  logic [SW-1:0] mask,
    input  logic          rd_en,
    output logic          int_n
);
    irq_st_e       state_q, state_d;
    logic [SW-1:0] prev_q;
    logic          chg;

    assign chg = |((stat ^ prev_q) & ~mask);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= stat;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (chg)           state_d = IRQ_PEND;
            IRQ_PEND: if (rd_en && !chg) state_d = IRQ_IDLE;
        endcase
    end

    // output
    always_comb int_n = (state_q != IRQ_PEND);
endmodule

// File: rtl/sup_filter_irq.sv
module sup_filter_irq
    import sup_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int HOLDW = 4,
    parameter int SMPW  = 4,
    parameter int CNTW  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_1ms,
    input  logic [NCH-1:0]           raw_a,
    input  logic [NCH-1:0]           raw_b,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_kind,
    input  logic [$clog2(NCH)-1:0]   cfg_ch,
    input  logic [((HOLDW > SMPW) ? HOLDW : SMPW)-1:0] cfg_data,
    input  logic                     rd_en,
    input  logic                     rd_all,
    input  logic [$clog2(NCH)-1:0]   rd_ch,
    output logic [2*NCH-1:0]         rd_data,
    output logic                     int_n
);
    localparam int CHW = $clog2(NCH);
    localparam int SW  = 2 * NCH;

    logic [NCH-1:0]   a_sync, b_sync;
    logic [NCH-1:0]   a_flt, b_flt;
    logic [NCH-1:0]   restart;
    logic [NCH-1:0]   deb_nz;
    logic [HOLDW-1:0] hold_q [NCH];
    logic [SMPW-1:0]  intv_q [NCH];
    logic [SW-1:0]    mask_q;
    logic [SW-1:0]    status_w;
    cfg_kind_e        kind;

    assign kind = cfg_kind_e'(cfg_kind);

    // settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                hold_q[c] <= '0;
                intv_q[c] <= '0;
            end
            mask_q <= '0;
        end else if (cfg_we) begin
            for (int c = 0; c < NCH; c++) begin
                if (cfg_ch == CHW'(c)) begin
                    unique case (kind)
                        CFG_HOLD:     hold_q[c]      <= cfg_data[HOLDW-1:0];
                        CFG_INTERVAL: intv_q[c]      <= cfg_data[SMPW-1:0];
                        CFG_MASK:     mask_q[2*c +: 2] <= cfg_data[1:0];
                        CFG_SPARE:    ;
                    endcase
                end
            end
        end
    end

    sup_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({raw_b, raw_a}),
        .q     ({b_sync, a_sync})
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign restart[c] = cfg_we && (kind == CFG_INTERVAL) && (cfg_ch == CHW'(c));
        assign deb_nz[c]  = (hold_q[c] != '0);

        sup_debounce #(.TW(HOLDW)) u_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_1ms),
            .din   (a_sync[c]),
            .hold  (hold_q[c]),
            .dout  (a_flt[c])
        );

        sup_integrator #(.CW(CNTW), .IW(SMPW)) u_intg (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_1ms),
            .restart  (restart[c]),
            .din      (b_sync[c]),
            .interval (intv_q[c]),
            .dout     (b_flt[c])
        );

        assign status_w[2*c]   = a_flt[c];
        assign status_w[2*c+1] = b_flt[c];
    end

    always_comb begin
        rd_data = '0;
        if (rd_all)
            rd_data = status_w;
        else
            rd_data[1:0] = status_w[{rd_ch, 1'b0} +: 2];
    end

    sup_irq #(.SW(SW)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (status_w),
        .mask  (mask_q),
        .rd_en (rd_en),
        .int_n (int_n)
    );
endmodule

// File: rtl/sup_filter_irq_chk.sv
module sup_filter_irq_chk #(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_1ms,
    input logic             rd_en,
    input logic             int_n,
    input logic [2*NCH-1:0] stat,
    input logic [NCH-1:0]   deb_nz
);
    logic [NCH-1:0] a_v, b_v;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            a_v[c] = stat[2*c];
            b_v[c] = stat[2*c+1];
        end
    end

    // R2: with every hold time nonzero, first-input bits move only on a tick
    a_r2_hold_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1ms && (&deb_nz)) |=> $stable(a_v));

    // R4: integrator outputs move only on a sampling tick
    a_r4_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_1ms |=> $stable(b_v));

    // R8: pending interrupt holds without a read
    a_r8_int_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && !rd_en) |=> !int_n);

    // R8: interrupt falls only after a status change
    a_r8_fall_after_change: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n) |-> ($past(stat) != $past(stat, 2)));

    // R10: read with a quiet status word clears the interrupt
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && rd_en && (stat == $past(stat))) |=> int_n);

    // R10: interrupt rises only through a read
    a_r10_rise_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_n) |-> $past(rd_en));
endmodule

bind sup_filter_irq sup_filter_irq_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1ms (tick_1ms),
    .rd_en    (rd_en),
    .int_n    (int_n),
    .stat     (status_w),
    .deb_nz   (deb_nz)
);

// File: tb/tb_sup_filter_irq.sv
module tb_sup_filter_irq;
    localparam int NCH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b0;
    logic [3:0] raw_a = '0;
    logic [3:0] raw_b = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_kind = '0;
    logic [1:0] cfg_ch = '0;
    logic [3:0] cfg_data = '0;
    logic       rd_en = 1'b0;
    logic       rd_all = 1'b1;
    logic [1:0] rd_ch = '0;
    logic [7:0] rd_data;
    logic       int_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic [3:0] exp_a = '0;
    logic [3:0] exp_b = '0;

    always #2 clk = ~clk;

    sup_filter_irq dut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
        .raw_a(raw_a), .raw_b(raw_b),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_ch(cfg_ch), .cfg_data(cfg_data),
        .rd_en(rd_en), .rd_all(rd_all), .rd_ch(rd_ch),
        .rd_data(rd_data), .int_n(int_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1ms = 1'b1;
            cyc(1);
            tick_1ms = 1'b0;
            cyc(1);
        end
    endtask

    task automatic cfg(input int kind, input int ch, input int data);
        cfg_kind = 2'(kind);
        cfg_ch   = 2'(ch);
        cfg_data = 4'(data);
        cfg_we   = 1'b1;
        cyc(1);
        cfg_we   = 1'b0;
    endtask

    task automatic read_ack();
        rd_en = 1'b1;
        cyc(1);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] exp_word();
        logic [7:0] w;
        for (int c = 0; c < NCH; c++) begin
            w[2*c]   = exp_a[c];
            w[2*c+1] = exp_b[c];
        end
        return w;
    endfunction

    function automatic logic a_bit(input int ch);
        return rd_data[2*ch];
    endfunction

    function automatic logic b_bit(input int ch);
        return rd_data[2*ch+1];
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R11: reset state
        chk(rd_data == 8'h00, "R11 status after reset", rd_data, 0);
        chk(int_n == 1'b1, "R11 int_n after reset", int_n, 1);

        // R1, R2: sweep every hold time on every channel
        for (int ch = 0; ch < NCH; ch++) begin
            for (int t = 0; t < 16; t++) begin
                logic nv;
                cfg(0, ch, t);
                nv = ~exp_a[ch];
                raw_a[ch] = nv;
                if (t == 0) begin
                    cyc(2);
                    chk(a_bit(ch) == exp_a[ch], "R1 not before third edge", a_bit(ch), exp_a[ch]);
                    cyc(1);
                    exp_a[ch] = nv;
                    chk(a_bit(ch) == nv, "R1 passthrough at third edge", a_bit(ch), nv);
                end else begin
                    cyc(3);
                    ticks(t - 1);
                    chk(a_bit(ch) == exp_a[ch], "R2 held before last tick", a_bit(ch), exp_a[ch]);
                    ticks(1);
                    exp_a[ch] = nv;
                    chk(a_bit(ch) == nv, "R2 update on T-th tick", a_bit(ch), nv);
                end
                read_ack();
            end
        end

        // R3: bounce restarts the count
        begin
            logic nv;
            cfg(0, 1, 4);
            nv = ~exp_a[1];
            raw_a[1] = nv;
            cyc(3);
            ticks(3);
            raw_a[1] = exp_a[1];
            cyc(3);
            raw_a[1] = nv;
            cyc(3);
            ticks(3);
            chk(a_bit(1) == exp_a[1], "R3 bounce restarted count", a_bit(1), exp_a[1]);
            ticks(1);
            exp_a[1] = nv;
            chk(a_bit(1) == nv, "R3 full count after bounce", a_bit(1), nv);
        end

        // R4, R5, R6: integrator over channels and intervals
        for (int ch = 0; ch < NCH; ch++) begin
            for (int k = 0; k < 3; k++) begin
                int n;
                int p;
                n = (k == 0) ? 0 : ((k == 1) ? 1 : 3 + ch);
                p = n + 1;
                cfg(1, ch, n);
                raw_b[ch] = 1'b1;
                cyc(3);
                ticks(7 * p - 1);
                chk(b_bit(ch) == 1'b0, "R6 R4 low before seventh sample", b_bit(ch), 0);
                ticks(1);
                chk(b_bit(ch) == 1'b1, "R6 R4 high on seventh sample", b_bit(ch), 1);
                ticks(5 * p);
                raw_b[ch] = 1'b0;
                cyc(3);
                ticks(3 * p);
                raw_b[ch] = 1'b1;
                cyc(3);
                ticks(3 * p);
                chk(b_bit(ch) == 1'b1, "R5 partial dip keeps high", b_bit(ch), 1);
                raw_b[ch] = 1'b0;
                cyc(3);
                ticks(7 * p - 1);
                chk(b_bit(ch) == 1'b1, "R5 R4 high until count zero", b_bit(ch), 1);
                ticks(1);
                chk(b_bit(ch) == 1'b0, "R4 low after seven low samples", b_bit(ch), 0);
            end
        end

        // R7: whole-word and per-channel reads
        cfg(1, 2, 0);
        raw_b[2] = 1'b1;
        cyc(3);
        ticks(7);
        exp_b[2] = 1'b1;
        rd_all = 1'b1;
        cyc(1);
        chk(rd_data == exp_word(), "R7 whole status word", rd_data, exp_word());
        for (int ch = 0; ch < NCH; ch++) begin
            logic [7:0] e;
            rd_all = 1'b0;
            rd_ch  = 2'(ch);
            cyc(1);
            e = {6'b0, exp_b[ch], exp_a[ch]};
            chk(rd_data == e, "R7 single channel read", rd_data, e);
        end
        rd_all = 1'b1;
        read_ack();
        cyc(2);
        chk(int_n == 1'b1, "R10 read acknowledges", int_n, 1);

        // R9: masked change does not interrupt
        cfg(0, 0, 0);
        cfg(2, 0, 1);
        raw_a[0] = ~exp_a[0];
        exp_a[0] = ~exp_a[0];
        cyc(6);
        chk(a_bit(0) == exp_a[0], "R9 masked bit still updates", a_bit(0), exp_a[0]);
        chk(int_n == 1'b1, "R9 masked change no interrupt", int_n, 1);

        // R8: unmasked change
        cfg(2, 0, 0);
        cfg(0, 1, 0);
        cyc(2);
        raw_a[1] = ~exp_a[1];
        exp_a[1] = ~exp_a[1];
        cyc(3);
        chk(int_n == 1'b1, "R8 not yet low at status edge", int_n, 1);
        cyc(1);
        chk(int_n == 1'b0, "R8 low one edge after change", int_n, 0);
        cyc(10);
        chk(int_n == 1'b0, "R8 stays low without read", int_n, 0);
        read_ack();
        chk(int_n == 1'b1, "R10 read clears", int_n, 1);

        // R10: change in the same cycle as the read
        cfg(0, 3, 0);
        raw_a[3] = ~exp_a[3];
        exp_a[3] = ~exp_a[3];
        cyc(5);
        chk(int_n == 1'b0, "R8 pending before race", int_n, 0);
        raw_a[1] = ~exp_a[1];
        exp_a[1] = ~exp_a[1];
        cyc(3);
        rd_en = 1'b1;
        cyc(1);
        rd_en = 1'b0;
        chk(int_n == 1'b0, "R10 same-cycle change keeps low", int_n, 0);
        cyc(3);
        chk(int_n == 1'b0, "R10 still low after race", int_n, 0);
        read_ack();
        chk(int_n == 1'b1, "R10 later read clears", int_n, 1);
        chk(rd_data == exp_word(), "R7 final status word", rd_data, exp_word());

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule